// File: doc/BRIEF.md
# Peripheral-to-Pad Routing Crossbar

This block connects on-chip peripheral signals to a bank of general-purpose pads. It offers two independent routing paths. The crossbar path lets every peripheral signal be placed on any pad of a 64-pad window starting at pad 8. Each peripheral signal has its own select register holding a one-based pad code. The fixed-group path lets a few wide interfaces claim predefined sets of pads above the window through small control fields: a serial-flash group with two pad sets, a UART group and an eMMC group.

Software programs the select registers through a simple write/read port. From then on the block steers each peripheral's output and output-enable onto its pad, and returns the pad's sampled input to that peripheral. Two peripherals can select the same pad. In that case a fixed priority decides which one drives it, and a sticky flag records the clash until the next reset.

Top module: `pxb_router`

## Requirements
- R1: After reset every select register and the group control register read 0, and every pad has output-enable 0.
- R2: Address k (0 ≤ k < 120) holds the 7-bit select of peripheral k, and address 120 holds the group control: bits 1:0 are the flash field, bit 2 the UART group and bit 3 the eMMC group. A write changes the routing from the clock edge that captures it. Reads of any other address return 0, and writes to them change nothing.
- R3: A select value v in 1..64 puts the peripheral's output and output-enable on pad v + 7 (v = 3 gives pad 10, v = 20 gives pad 27).
- R4: A routed peripheral's input equals the sampled input of its pad. An unrouted peripheral's input is 0.
- R5: Select values 0 and 65..127 both leave the peripheral unrouted.
- R6: When several peripherals select one pad, the one with the lowest index drives it. Every one of them still receives that pad's input.
- R7: `conflict_o` rises one clock after two routed selects share a pad. It stays high until reset.
- R8: Flash field 1 maps group lanes 0..3 onto pads 83, 84, 86 and 87. Field 2 maps them onto pads 76, 78, 79 and 81. Fields 0 and 3 claim nothing, and the flash lanes then read 0.
- R9: The UART group bit maps lane 4 onto pad 88 (transmit) and lane 5 onto pad 89 (receive).
- R10: The eMMC group bit maps lanes 6..15 onto pads 72..81. On pads that flash field 2 also claims, the eMMC lane drives the pad, and the displaced flash lane reads 0.
- R11: Pads that no path claims have output 0 and output-enable 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 8 | Register address |
| wdata_i | input | 8 | Register write data |
| rdata_o | output | 8 | Register read data for `addr_i` |
| periph_out_i | input | 120 | Crossbar peripheral output values |
| periph_oe_i | input | 120 | Crossbar peripheral output enables |
| periph_in_o | output | 120 | Crossbar peripheral inputs taken from pads |
| grp_out_i | input | 16 | Fixed-group lane output values |
| grp_oe_i | input | 16 | Fixed-group lane output enables |
| grp_in_o | output | 16 | Fixed-group lane inputs taken from pads |
| pad_out_o | output | 99 | Pad drive values |
| pad_oe_o | output | 99 | Pad output enables |
| pad_in_i | input | 99 | Sampled pad inputs |
| conflict_o | output | 1 | Sticky shared-pad flag |

## Verification
The only internal state is the select and group registers plus the conflict flag. A wrong register value therefore shows up at the pads or on the peripheral inputs in the same cycle as the corrupted routing, and it can also be read back through `rdata_o`. A pad-priority error appears only while two selects collide, so the stimulus keeps collisions frequent. A wrong conflict flag shows one cycle after the collision begins, or on the first cycle after a reset that failed to clear it. Each cycle, every output is compared against a behavioural model of the register file and routing.

// File: rtl/pxb_pkg.sv
package pxb_pkg;

    // fixed-group lane layout
    localparam int FL_LANES  = 4;
    localparam int UA_LANES  = 2;
    localparam int EM_LANES  = 10;
    localparam int UA_BASE   = FL_LANES;
    localparam int EM_BASE   = FL_LANES + UA_LANES;
    localparam int GRP_LANES = FL_LANES + UA_LANES + EM_LANES;

    // pad anchors of the fixed groups
    localparam int UA_PAD0   = 88;
    localparam int EM_PAD0   = 72;
    localparam int EM_PADN   = EM_PAD0 + EM_LANES - 1;

    typedef struct packed {
        logic       emmc;
        logic       uart0;
        logic [1:0] flash;
    } grp_cfg_t;

    // pad used by a flash lane in a given mode (1 or 2)
    function automatic int flash_pad(input int mode, input int lane);
        int p;
        if (mode == 1) begin
            p = (lane < 2) ? 83 + lane : 84 + lane;
        end else begin
            case (lane)
                0:       p = 76;
                1:       p = 78;
                2:       p = 79;
                default: p = 81;
            endcase
        end
        return p;
    endfunction

endpackage

// File: rtl/pxb_regs.sv
module pxb_regs
    import pxb_pkg::*;
#(
    parameter int N_PERIPH = 120,
    parameter int SEL_W    = 7,
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 8
) (
    input  logic                             clk_i,
    input  logic                             rst_i,
    input  logic                             wr_en_i,
    input  logic [ADDR_W-1:0]                addr_i,
    input  logic [DATA_W-1:0]                wdata_i,
    input  logic                             conflict_now_i,
    output logic [N_PERIPH-1:0][SEL_W-1:0]   sel_o,
    output grp_cfg_t                         grp_o,
    output logic                             conflict_o,
    output logic [DATA_W-1:0]                rdata_o
);

    localparam int               IDX_W    = $clog2(N_PERIPH);
    localparam logic [ADDR_W-1:0] LAST_SEL = ADDR_W'(N_PERIPH - 1);
    localparam logic [ADDR_W-1:0] GRP_ADDR = ADDR_W'(N_PERIPH);
    localparam int               GRP_W    = $bits(grp_cfg_t);

    typedef struct packed {
        logic [N_PERIPH-1:0][SEL_W-1:0] sel;
        grp_cfg_t                       grp;
        logic                           conflict;
    } reg_state_t;

    reg_state_t st_d, st_q;

    logic unused_wdata;
    assign unused_wdata = ^wdata_i;

    always_comb begin
        st_d = st_q;
        if (wr_en_i) begin
            if (addr_i <= LAST_SEL) begin
                st_d.sel[addr_i[IDX_W-1:0]] = wdata_i[SEL_W-1:0];
            end else if (addr_i == GRP_ADDR) begin
                st_d.grp = grp_cfg_t'(wdata_i[GRP_W-1:0]);
            end
        end
        st_d.conflict = st_q.conflict | conflict_now_i;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) st_q <= '0;
        else       st_q <= st_d;
    end

    always_comb begin
        rdata_o = '0;
        if (addr_i <= LAST_SEL) begin
            rdata_o = DATA_W'(st_q.sel[addr_i[IDX_W-1:0]]);
        end else if (addr_i == GRP_ADDR) begin
            rdata_o = DATA_W'(st_q.grp);
        end
    end

    assign sel_o      = st_q.sel;
    assign grp_o      = st_q.grp;
    assign conflict_o = st_q.conflict;

    p_grp_write_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        (wr_en_i && addr_i == GRP_ADDR) |=> (grp_o == $past(wdata_i[GRP_W-1:0])));

    p_conflict_set_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        conflict_now_i |=> conflict_o);

    p_conflict_sticky_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        conflict_o |=> conflict_o);

endmodule

// File: rtl/pxb_xbar.sv
module pxb_xbar #(
    parameter int N_PERIPH = 120,
    parameter int N_PADS   = 99,
    parameter int WIN_BASE = 8,
    parameter int WIN_PADS = 64,
    parameter int SEL_W    = 7
) (
    input  logic                           clk_i,
    input  logic                           rst_i,
    input  logic [N_PERIPH-1:0][SEL_W-1:0] sel_i,
    input  logic [N_PERIPH-1:0]            p_out_i,
    input  logic [N_PERIPH-1:0]            p_oe_i,
    input  logic [N_PADS-1:0]              pad_in_i,
    output logic [N_PADS-1:0]              pad_out_o,
    output logic [N_PADS-1:0]              pad_oe_o,
    output logic [N_PERIPH-1:0]            p_in_o,
    output logic                           conflict_o
);

    localparam int               WIN_W   = $clog2(WIN_PADS);
    localparam logic [SEL_W-1:0] SEL_MAX = SEL_W'(WIN_PADS);

    logic [WIN_PADS-1:0] win_in, win_out, win_oe, claim;
    logic [WIN_W-1:0]    widx;
    logic                unused_pads;

    assign win_in      = pad_in_i[WIN_BASE +: WIN_PADS];
    assign unused_pads = ^pad_in_i;

    // walk peripherals from lowest index; the first claimant owns a pad
    always_comb begin
        win_out    = '0;
        win_oe     = '0;
        claim      = '0;
        p_in_o     = '0;
        conflict_o = 1'b0;
        widx       = '0;
        for (int i = 0; i < N_PERIPH; i++) begin
            if (sel_i[i] != '0 && sel_i[i] <= SEL_MAX) begin
                widx      = WIN_W'(sel_i[i] - SEL_W'(1));
                p_in_o[i] = win_in[widx];
                if (claim[widx]) begin
                    conflict_o = 1'b1;
                end else begin
                    claim[widx]   = 1'b1;
                    win_out[widx] = p_out_i[i];
                    win_oe[widx]  = p_oe_i[i];
                end
            end
        end
    end

    always_comb begin
        pad_out_o = '0;
        pad_oe_o  = '0;
        pad_out_o[WIN_BASE +: WIN_PADS] = win_out;
        pad_oe_o[WIN_BASE +: WIN_PADS]  = win_oe;
    end

    p_unrouted_in_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        (sel_i[0] == '0) |-> (p_in_o[0] == 1'b0));

    p_code_one_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        (sel_i[0] == SEL_W'(1)) |-> (pad_oe_o[WIN_BASE] == p_oe_i[0] &&
                                     pad_out_o[WIN_BASE] == p_out_i[0]));

    p_lowest_wins_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        (sel_i[1] == SEL_W'(2) && sel_i[0] == SEL_W'(2))
            |-> (pad_out_o[WIN_BASE+1] == p_out_i[0] && conflict_o));

endmodule

// File: rtl/pxb_groups.sv
module pxb_groups
    import pxb_pkg::*;
#(
    parameter int N_PADS = 99
) (
    input  logic                 clk_i,
    input  logic                 rst_i,
    input  grp_cfg_t             grp_i,
    input  logic [GRP_LANES-1:0] g_out_i,
    input  logic [GRP_LANES-1:0] g_oe_i,
    input  logic [N_PADS-1:0]    pad_in_i,
    output logic [N_PADS-1:0]    pad_out_o,
    output logic [N_PADS-1:0]    pad_oe_o,
    output logic [GRP_LANES-1:0] g_in_o
);

    logic flash_on;
    logic unused_pads;

    assign flash_on    = (grp_i.flash == 2'd1) || (grp_i.flash == 2'd2);
    assign unused_pads = ^pad_in_i;

    always_comb begin
        pad_out_o = '0;
        pad_oe_o  = '0;
        g_in_o    = '0;

        for (int k = 0; k < EM_LANES; k++) begin
            if (grp_i.emmc) begin
                pad_out_o[EM_PAD0+k] = g_out_i[EM_BASE+k];
                pad_oe_o[EM_PAD0+k]  = g_oe_i[EM_BASE+k];
                g_in_o[EM_BASE+k]    = pad_in_i[EM_PAD0+k];
            end
        end

        for (int k = 0; k < UA_LANES; k++) begin
            if (grp_i.uart0) begin
                pad_out_o[UA_PAD0+k] = g_out_i[UA_BASE+k];
                pad_oe_o[UA_PAD0+k]  = g_oe_i[UA_BASE+k];
                g_in_o[UA_BASE+k]    = pad_in_i[UA_PAD0+k];
            end
        end

        // flash lanes yield to the eMMC group on shared pads
        for (int k = 0; k < FL_LANES; k++) begin
            for (int m = 1; m <= 2; m++) begin
                if (flash_on && int'(grp_i.flash) == m &&
                    !(grp_i.emmc && flash_pad(m, k) >= EM_PAD0 &&
                      flash_pad(m, k) <= EM_PADN)) begin
                    pad_out_o[flash_pad(m, k)] = g_out_i[k];
                    pad_oe_o[flash_pad(m, k)]  = g_oe_i[k];
                    g_in_o[k]                  = pad_in_i[flash_pad(m, k)];
                end
            end
        end
    end

    p_emmc_wins_r10: assert property (@(posedge clk_i) disable iff (rst_i)
        (grp_i.emmc && grp_i.flash == 2'd2)
            |-> (pad_out_o[76] == g_out_i[EM_BASE+4] && g_in_o[0] == 1'b0));

    p_uart_pads_r9: assert property (@(posedge clk_i) disable iff (rst_i)
        grp_i.uart0 |-> (pad_oe_o[UA_PAD0] == g_oe_i[UA_BASE] &&
                         g_in_o[UA_BASE+1] == pad_in_i[UA_PAD0+1]));

    p_flash_idle_r8: assert property (@(posedge clk_i) disable iff (rst_i)
        (grp_i.flash == 2'd0 || grp_i.flash == 2'd3) |-> (g_in_o[FL_LANES-1:0] == '0));

endmodule

// File: rtl/pxb_router.sv
module pxb_router
    import pxb_pkg::*;
#(
    parameter int N_PERIPH = 120,
    parameter int N_PADS   = 99,
    parameter int WIN_BASE = 8,
    parameter int WIN_PADS = 64,
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 8
) (
    input  logic                 clk_i,
    input  logic                 rst_i,
    input  logic                 wr_en_i,
    input  logic [ADDR_W-1:0]    addr_i,
    input  logic [DATA_W-1:0]    wdata_i,
    output logic [DATA_W-1:0]    rdata_o,
    input  logic [N_PERIPH-1:0]  periph_out_i,
    input  logic [N_PERIPH-1:0]  periph_oe_i,
    output logic [N_PERIPH-1:0]  periph_in_o,
    input  logic [GRP_LANES-1:0] grp_out_i,
    input  logic [GRP_LANES-1:0] grp_oe_i,
    output logic [GRP_LANES-1:0] grp_in_o,
    output logic [N_PADS-1:0]    pad_out_o,
    output logic [N_PADS-1:0]    pad_oe_o,
    input  logic [N_PADS-1:0]    pad_in_i,
    output logic                 conflict_o
);

    localparam int SEL_W = $clog2(WIN_PADS + 1);

    logic [N_PERIPH-1:0][SEL_W-1:0] sel;
    grp_cfg_t                       grp;
    logic                           conflict_now;
    logic [N_PADS-1:0]              xb_out, xb_oe, gr_out, gr_oe;

    pxb_regs #(
        .N_PERIPH (N_PERIPH),
        .SEL_W    (SEL_W),
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W)
    ) u_regs (
        .clk_i          (clk_i),
        .rst_i          (rst_i),
        .wr_en_i        (wr_en_i),
        .addr_i         (addr_i),
        .wdata_i        (wdata_i),
        .conflict_now_i (conflict_now),
        .sel_o          (sel),
        .grp_o          (grp),
        .conflict_o     (conflict_o),
        .rdata_o        (rdata_o)
    );

    pxb_xbar #(
        .N_PERIPH (N_PERIPH),
        .N_PADS   (N_PADS),
        .WIN_BASE (WIN_BASE),
        .WIN_PADS (WIN_PADS),
        .SEL_W    (SEL_W)
    ) u_xbar (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .sel_i      (sel),
        .p_out_i    (periph_out_i),
        .p_oe_i     (periph_oe_i),
        .pad_in_i   (pad_in_i),
        .pad_out_o  (xb_out),
        .pad_oe_o   (xb_oe),
        .p_in_o     (periph_in_o),
        .conflict_o (conflict_now)
    );

    pxb_groups #(
        .N_PADS (N_PADS)
    ) u_groups (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .grp_i     (grp),
        .g_out_i   (grp_out_i),
        .g_oe_i    (grp_oe_i),
        .pad_in_i  (pad_in_i),
        .pad_out_o (gr_out),
        .pad_oe_o  (gr_oe),
        .g_in_o    (grp_in_o)
    );

    // crossbar window and group pads are disjoint, so a plain merge suffices
    assign pad_out_o = xb_out | gr_out;
    assign pad_oe_o  = xb_oe | gr_oe;

    p_paths_disjoint_r11: assert property (@(posedge clk_i) disable iff (rst_i)
        ((xb_oe & gr_oe) == '0));

endmodule

// File: tb/tb_pxb_router.sv
module tb_pxb_router;
    localparam int NP = 120;
    localparam int NPAD = 99;
    localparam int GL = 16;

    logic clk = 0, rst = 1;
    logic wr_en = 0;
    logic [7:0] addr = 0, wdata = 0, rdata;
    logic [NP-1:0] p_out = 0, p_oe = 0, p_in;
    logic [GL-1:0] g_out = 0, g_oe = 0, g_in;
    logic [NPAD-1:0] pad_out, pad_oe, pad_in = 0;
    logic conflict;

    int total = 0, bad = 0;
    bit cmp_on = 0;

    int msel [NP];
    int mgrp;
    bit mconf;
    logic [NPAD-1:0] e_out, e_oe;
    logic [NP-1:0] e_pin;
    logic [GL-1:0] e_gin;
    bit e_conf;
    int fl1 [4] = '{83, 84, 86, 87};
    int fl2 [4] = '{76, 78, 79, 81};

    always #10 clk = ~clk;

    pxb_router dut (
        .clk_i(clk), .rst_i(rst), .wr_en_i(wr_en), .addr_i(addr),
        .wdata_i(wdata), .rdata_o(rdata), .periph_out_i(p_out),
        .periph_oe_i(p_oe), .periph_in_o(p_in), .grp_out_i(g_out),
        .grp_oe_i(g_oe), .grp_in_o(g_in), .pad_out_o(pad_out),
        .pad_oe_o(pad_oe), .pad_in_i(pad_in), .conflict_o(conflict)
    );

    task automatic check(string tag, logic [127:0] got, logic [127:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    // behavioural expectation from the requirement text
    task automatic model_eval();
        bit taken [NPAD];
        int f;
        bit em;
        e_out = 0; e_oe = 0; e_pin = 0; e_gin = 0; e_conf = 0;
        foreach (taken[j]) taken[j] = 0;
        for (int i = 0; i < NP; i++) begin
            if (msel[i] >= 1 && msel[i] <= 64) begin
                int p = msel[i] + 7;
                e_pin[i] = pad_in[p];
                if (taken[p]) e_conf = 1;
                else begin
                    taken[p] = 1; e_out[p] = p_out[i]; e_oe[p] = p_oe[i];
                end
            end
        end
        em = mgrp[3];
        if (em) for (int k = 0; k < 10; k++) begin
            e_out[72+k] = g_out[6+k]; e_oe[72+k] = g_oe[6+k]; e_gin[6+k] = pad_in[72+k];
        end
        if (mgrp[2]) for (int k = 0; k < 2; k++) begin
            e_out[88+k] = g_out[4+k]; e_oe[88+k] = g_oe[4+k]; e_gin[4+k] = pad_in[88+k];
        end
        f = mgrp & 3;
        if (f == 1 || f == 2) for (int k = 0; k < 4; k++) begin
            int p = (f == 1) ? fl1[k] : fl2[k];
            if (!(em && p >= 72 && p <= 81)) begin
                e_out[p] = g_out[k]; e_oe[p] = g_oe[k]; e_gin[k] = pad_in[p];
            end
        end
    endtask

    always @(posedge clk) begin
        if (rst) begin
            foreach (msel[i]) msel[i] = 0;
            mgrp = 0; mconf = 0;
        end else begin
            model_eval();
            mconf = mconf | e_conf;
            if (wr_en) begin
                if (addr < NP) msel[addr] = wdata & 127;
                else if (addr == NP) mgrp = wdata & 15;
            end
        end
    end

    always @(posedge clk) begin
        #5;
        if (cmp_on) begin
            int er;
            model_eval();
            er = (addr < NP) ? msel[addr] : (addr == NP) ? mgrp : 0;
            check("R3/R6/R8 pad_out", pad_out, e_out);
            check("R11 pad_oe", pad_oe, e_oe);
            check("R4 periph_in", p_in, e_pin);
            check("R10 grp_in", g_in, e_gin);
            check("R7 conflict", conflict, mconf);
            check("R2 rdata", rdata, er);
        end
    end

    task automatic wr(int a, int d);
        @(negedge clk); wr_en = 1; addr = a[7:0]; wdata = d[7:0];
        @(negedge clk); wr_en = 0;
    endtask

    task automatic rd(string tag, int a, int exp);
        addr = a[7:0]; #1;
        check(tag, rdata, exp);
    endtask

    initial begin
        #(20 * 150000);
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        cmp_on = 1;
        // R1 reset state
        rd("R1 sel0", 0, 0);
        rd("R1 grp", NP, 0);
        check("R1 pad_oe", pad_oe, 0);
        // R3 routing: code 3 -> pad 10, code 20 -> pad 27
        p_out = 0; p_oe = '1;
        p_out[5] = 1;
        wr(5, 3);
        #1 check("R3 pad10 out", pad_out[10], 1);
        check("R3 pad10 oe", pad_oe[10], 1);
        p_out[12] = 1;
        wr(12, 20);
        #1 check("R3 pad27 out", pad_out[27], 1);
        rd("R2 readback", 12, 20);
        // R4 inputs
        pad_in[10] = 1; #1;
        check("R4 routed in", p_in[5], 1);
        pad_in = '1; #1;
        check("R4 unrouted in", p_in[6], 0);
        // R5 out-of-range code
        p_out[7] = 1;
        wr(7, 65);
        #1 check("R5 code65 in", p_in[7], 0);
        check("R5 code65 pads", pad_oe[71:8] & ~(64'h1 << 2) & ~(64'h1 << 19), 0);
        // R6 priority; R7 sticky
        check("R7 idle", conflict, 0);
        p_out[9] = 0;
        wr(9, 3);
        #1 check("R6 lowest wins", pad_out[10], 1);
        check("R6 shared in", p_in[9], 1);
        @(negedge clk); #1;
        check("R7 raised", conflict, 1);
        wr(9, 4);
        @(negedge clk); #1;
        check("R7 sticky", conflict, 1);
        // R8 flash groups
        g_out = 16'h000B; g_oe = '1; pad_in = 0;
        wr(NP, 1);
        #1 check("R8 mode1", {pad_out[87], pad_out[86], pad_out[84], pad_out[83]}, 4'b1011);
        wr(NP, 2);
        #1 check("R8 mode2", {pad_out[81], pad_out[79], pad_out[78], pad_out[76]}, 4'b1011);
        wr(NP, 3);
        #1 check("R8 mode3 none", pad_oe[98:72], 0);
        // R9 UART group
        g_out = 16'h0010; pad_in[89] = 1;
        wr(NP, 4);
        #1 check("R9 tx pad", pad_out[88], 1);
        check("R9 rx lane", g_in[5], 1);
        // R10 eMMC over flash mode 2
        g_out = 16'h0400; pad_in[76] = 1;
        wr(NP, 8 | 2);
        #1 check("R10 pad76 emmc", pad_out[76], 1);
        check("R10 flash lane0 blocked", g_in[0], 0);
        check("R10 emmc lane in", g_in[10], 1);
        // R11 unclaimed pads
        check("R11 low pads", pad_oe[7:0], 0);
        check("R11 high pads", pad_oe[98:90], 0);
        // R2 unmapped address
        wr(200, 8'h55);
        rd("R2 unmapped", 200, 0);
        rd("R2 grp kept", NP, 10);
        // R7 reset clears the flag
        @(negedge clk); rst = 1;
        @(negedge clk); rst = 0; #1;
        check("R7 reset clear", conflict, 0);
        check("R1 after reset", pad_oe, 0);
        // random phase
        for (int n = 0; n < 3000; n++) begin
            @(negedge clk);
            wr_en = ($urandom_range(0, 3) != 0);
            case ($urandom_range(0, 9))
                0: addr = NP[7:0];
                1: addr = 8'($urandom_range(121, 255));
                default: addr = 8'($urandom_range(0, NP - 1));
            endcase
            wdata = (addr == NP) ? 8'($urandom) : 8'($urandom_range(0, 80));
            p_out = {$urandom, $urandom, $urandom, $urandom};
            p_oe  = {$urandom, $urandom, $urandom, $urandom};
            g_out = 16'($urandom); g_oe = 16'($urandom);
            pad_in = {$urandom, $urandom, $urandom, $urandom};
            if (n == 1500) rst = 1;
            if (n == 1502) rst = 0;
        end
        @(negedge clk); wr_en = 0;
        @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule